// File: doc/BRIEF.md
# Role-Swap Auto-Connect Controller

This block sits on the A-device side of a USB On-The-Go host role swap. Firmware arms it and puts the bus into suspend. The peer then releases its D+ pull-up, which the A-device sees as single-ended zero (SE0), meaning both D+ and D- are low. When that happens, the block switches on the local D+ pull-up by itself. Software is not involved, so the turnaround limit of under 3 ms holds however slowly the interrupt handler runs.

SE0 must be present for `SE0_SAMPLES` consecutive clock samples before it is accepted, so short glitches are ignored. Once the pull-up is on and D+ reads high, a status flag rises. The interrupt unit takes this flag as the role-swap event. A timeout measured in 1 µs ticks gives up if D+ never rises. Clearing the arm input releases everything at once.

Top module: `rswap_autoconn`

## Requirements
- R1: While reset is asserted, `dp_pullup_o` and `swap_flag_o` are both 0.
- R2: In any cycle that samples `arm_i` low, both outputs are 0 after that clock edge, whatever the line or suspend state.
- R3: Suppose the block has been armed and suspended for at least one edge (the entry edge). If SE0 is then sampled on `SE0_SAMPLES` consecutive edges, `dp_pullup_o` is 1 right after the last of those edges, and never before it.
- R4: SE0 means `dp_i`=0 and `dm_i`=0. The pattern `dp_i`=0 with `dm_i`=1 never counts toward R3.
- R5: SE0 seen while `suspend_i` is 0 never turns on the pull-up. If suspend drops before SE0 is accepted, the block goes back to idle. After suspend returns, it needs one entry edge and then a fresh run of `SE0_SAMPLES` samples.
- R6: SE0 that is broken off before `SE0_SAMPLES` samples leaves the pull-up off. The next SE0 run counts from zero.
- R7: If `dp_i` is sampled high while the pull-up is on, `swap_flag_o` is 1 after that edge. Both outputs then stay at 1 for as long as `arm_i` is held.
- R8: The pull-up may be on with `dp_i` staying low. In that case, on the `TIMEOUT_US`-th edge that samples `tick_us_i` high, the pull-up is released. No new attempt starts until `arm_i` has been low for at least one edge. Edges without a tick do not advance the timeout.
- R9: `swap_flag_o` is never 1 while `dp_pullup_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Firmware enable for the auto-connect sequence |
| suspend_i | input | 1 | Bus has been put into suspend by this device |
| dp_i | input | 1 | Synchronised D+ line state |
| dm_i | input | 1 | Synchronised D- line state |
| tick_us_i | input | 1 | One-cycle pulse every microsecond |
| dp_pullup_o | output | 1 | D+ pull-up enable |
| swap_flag_o | output | 1 | Role-swap connect event flag for the interrupt unit |

## Verification
The assertions assume the line inputs are already synchronised to `clk` and free of metastability. They also assume `tick_us_i` is an ordinary level sampled once per edge. The stimulus keeps to these assumptions: it changes every input only on the falling clock edge and holds it for whole cycles. The bench sweeps SE0 run lengths around the filter threshold, aborts a run by dropping suspend, and holds D+ low to drive the timeout path.

// File: rtl/rswap_autoconn.sv
module rswap_autoconn #(
  parameter int SE0_SAMPLES = 4,
  parameter int TIMEOUT_US  = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic suspend_i,
  input  logic dp_i,
  input  logic dm_i,
  input  logic tick_us_i,
  output logic dp_pullup_o,
  output logic swap_flag_o
);
  localparam int FW = $clog2(SE0_SAMPLES + 1);
  localparam int TW = $clog2(TIMEOUT_US + 1);

  typedef enum logic [1:0] {IDLE, ARMED_SUSP, PULLUP_ON, DONE} st_t;

  st_t           st_q, st_d;
  logic [FW-1:0] se0_q;
  logic [TW-1:0] tmo_q;
  logic          spent_q;
  logic          se0, accept, expire;

  assign se0    = !dp_i && !dm_i;
  assign accept = se0 && (se0_q == FW'(SE0_SAMPLES - 1));
  assign expire = tick_us_i && (tmo_q == TW'(TIMEOUT_US - 1));

  always_comb begin
    st_d = st_q;
    if (!arm_i) st_d = IDLE;
    else begin
      case (st_q)
        IDLE:       if (suspend_i && !spent_q) st_d = ARMED_SUSP;
        ARMED_SUSP: if (!suspend_i) st_d = IDLE;
                    else if (accept) st_d = PULLUP_ON;
        PULLUP_ON:  if (dp_i) st_d = DONE;
                    else if (expire) st_d = IDLE;
        default:    st_d = DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= IDLE;
      se0_q   <= '0;
      tmo_q   <= '0;
      spent_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ARMED_SUSP && se0 && suspend_i) se0_q <= se0_q + 1'b1;
      else se0_q <= '0;
      if (st_q != PULLUP_ON) tmo_q <= '0;
      else if (tick_us_i) tmo_q <= tmo_q + 1'b1;
      if (!arm_i) spent_q <= 1'b0;
      else if (st_q == PULLUP_ON && !dp_i && expire) spent_q <= 1'b1;
    end
  end

  assign dp_pullup_o = (st_q == PULLUP_ON) || (st_q == DONE);
  assign swap_flag_o = (st_q == DONE);
endmodule

module rswap_autoconn_chk #(
  parameter int SE0_SAMPLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic arm_i,
  input logic suspend_i,
  input logic dp_i,
  input logic dm_i,
  input logic tick_us_i,
  input logic dp_pullup_o,
  input logic swap_flag_o
);
  localparam int CW = $clog2(SE0_SAMPLES + 1);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (!(arm_i && suspend_i && !dp_i && !dm_i)) run_q <= '0;
    else if (run_q != CW'(SE0_SAMPLES)) run_q <= run_q + 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!dp_pullup_o && !swap_flag_o));

  a_r2_disarm_release: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |=> (!dp_pullup_o && !swap_flag_o));

  a_r3_filtered_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dp_pullup_o) |-> (run_q == CW'(SE0_SAMPLES)));

  a_r5_needs_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend_i && !dp_pullup_o) |=> !dp_pullup_o);

  a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_flag_o && arm_i) |=> swap_flag_o);

  a_r9_flag_with_pullup: assert property (@(posedge clk) disable iff (!rst_n)
    swap_flag_o |-> dp_pullup_o);

  logic unused_tick;
  assign unused_tick = tick_us_i;
endmodule

bind rswap_autoconn rswap_autoconn_chk #(.SE0_SAMPLES(SE0_SAMPLES)) chk_i (.*);

// File: tb/rswap_autoconn_tb_top.sv
module rswap_autoconn_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;
  localparam int T = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 1'b0, susp = 1'b0, dp = 1'b1, dm = 1'b0, tick = 1'b0;
  logic pu, fl;
  int vectors = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rswap_autoconn #(.SE0_SAMPLES(N), .TIMEOUT_US(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .suspend_i(susp), .dp_i(dp),
    .dm_i(dm), .tick_us_i(tick), .dp_pullup_o(pu), .swap_flag_o(fl));

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(logic exp_pu, logic exp_fl, string req);
    vectors++;
    if (pu !== exp_pu || fl !== exp_fl) begin
      fails++;
      $display("FAIL %s: pullup=%b flag=%b expected pullup=%b flag=%b",
               req, pu, fl, exp_pu, exp_fl);
    end
  endtask

  task automatic rearm();
    arm = 0; dp = 1; dm = 0; susp = 1; tick = 0;
    step(); check(0, 0, "R2 disarmed");
    arm = 1;
    step(); check(0, 0, "R2 entry edge");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cyc);
      finish_run();
    end
  end

  initial begin
    step(); check(0, 0, "R1");
    step(); check(0, 0, "R1");
    rst_n = 1;

    for (int len = 1; len <= N + 2; len++) begin
      rearm();
      dp = 0; dm = 0;
      for (int i = 1; i <= len; i++) begin
        step(); check(i >= N, 0, (len < N) ? "R6 short SE0" : "R3 SE0 filter");
      end
      dp = 1;
      step(); check(len >= N, len >= N, "R7 D+ high sets flag");
      step(); check(len >= N, len >= N, "R7 flag held");
      if (len < N) begin
        dp = 0;
        for (int i = 1; i < N; i++) begin
          step(); check(0, 0, "R6 count restarts");
        end
        dp = 1;
        step(); check(0, 0, "R6 count restarts");
      end
    end

    rearm();
    dp = 0; dm = 1;
    for (int i = 0; i < 2 * N; i++) begin
      step(); check(0, 0, "R4 dm high not SE0");
    end

    rearm();
    susp = 0; step(); check(0, 0, "R5 suspend low");
    dp = 0; dm = 0;
    for (int i = 0; i < 2 * N; i++) begin
      step(); check(0, 0, "R5 SE0 without suspend");
    end

    rearm();
    dp = 0; dm = 0;
    for (int i = 1; i < N; i++) begin
      step(); check(0, 0, "R5 partial run");
    end
    susp = 0; step(); check(0, 0, "R5 abort");
    susp = 1;
    for (int j = 1; j <= N + 1; j++) begin
      step(); check(j == N + 1, 0, "R5 fresh run after abort");
    end

    rearm();
    arm = 0; dp = 0; dm = 0;
    for (int i = 0; i < 2 * N; i++) begin
      step(); check(0, 0, "R2 unarmed SE0");
    end

    rearm();
    dp = 0; dm = 0;
    for (int i = 1; i <= N; i++) begin
      step(); check(i >= N, 0, "R3 before timeout");
    end
    for (int i = 0; i < 10; i++) begin
      step(); check(1, 0, "R8 no tick no timeout");
    end
    tick = 1;
    for (int k = 1; k <= T; k++) begin
      step(); check(k < T, 0, "R8 timeout count");
    end
    for (int i = 0; i < 2 * N + 2; i++) begin
      step(); check(0, 0, "R8 no retry until disarm");
    end
    tick = 0;
    rearm();
    dp = 0; dm = 0;
    for (int i = 1; i <= N; i++) begin
      step(); check(i >= N, 0, "R8 retry after disarm");
    end
    dp = 1;
    step(); check(1, 1, "R7 after retry");
    arm = 0;
    step(); check(0, 0, "R2 release after done");

    finish_run();
  end
endmodule